// File: doc/BRIEF.md
# Multiphase Oscillator Phase Digitizer

This block turns one snapshot of a ring oscillator into a phase-increment word once per conversion period. It receives the fifteen sampled stage outputs of a differential ring, the value of a free-running whole-cycle counter captured at the same moment, and a one-bit extra-count flag from an external time sampler. The fifteen taps are encoded into a fractional phase in thirtieths of a cycle. The captured count is corrected for the retiming ambiguity that inflates it by one in the second half of the cycle. The corrected count and the fraction are combined, and the difference from the previous conversion is the output.

The output is the phase advanced by the oscillator over one period, in units of 1/30 cycle. This is a first-order noise-shaped measure of the oscillator frequency. Because the counter only needs to track whole-cycle wrap-around modulo its own width, the oscillator centre frequency never has to be trimmed.

Top module: `mpd_phase_digitizer`

## Requirements
- R1: A tap word is valid when it is a Johnson-counter state: with the top tap (bit 14) at 0 it has the form 0…01…1 from the LSB, and with bit 14 at 1 it has the form 1…10…0. The phase code is the number of ones when bit 14 is 0, and 30 minus the number of ones when bit 14 is 1. This gives codes 0 to 29.
- R2: A tap word that is not valid raises `err_o` in the output cycle of that conversion. The last valid phase code is used in its place, and this code is 0 after reset.
- R3: For codes 23 to 29, the captured count is decremented by one and `xflag_i` has no effect.
- R4: For codes 0 to 7, the captured count is used unchanged and `xflag_i` has no effect.
- R5: For codes 8 to 22, the captured count is decremented by one exactly when `xflag_i` is 1.
- R6: `word_o` = ((corrected count − previous corrected count) mod 2^CNT_W) × 30 + code − previous code, taken modulo 2^(CNT_W+5).
- R7: A wrap of the captured counter between conversions, including a wrap produced by the decrement itself, yields the true phase advance.
- R8: The first conversion after reset produces no `valid_o`; it only stores the reference.
- R9: `valid_o` is high for exactly the cycle after each conversion strobe (from the second conversion on), and `word_o` holds its value between strobes.
- R10: While reset is active, `valid_o`, `err_o` and `word_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | One-cycle strobe: taps, count and flag are valid |
| taps_i | input | 15 | Sampled oscillator stage outputs |
| cnt_i | input | CNT_W | Captured whole-cycle counter |
| xflag_i | input | 1 | Extra-count indication from the time sampler |
| word_o | output | CNT_W+5 | Phase advance since the previous conversion, 1/30 cycle units |
| valid_o | output | 1 | `word_o` updated this cycle |
| err_o | output | 1 | The conversion just reported had an invalid tap word |

## Verification
The two functions most likely to meet in one cycle are the half-cycle decrement and the modulo counter difference. A captured count of 0 with a phase code in the upper band must be decremented into the counter's maximum value, and the result must still subtract cleanly from the previous count. The bench starts its counter offset close to full scale and advances the oscillator by large and irregular steps, so these wraps happen many times with every phase band. Each word is judged against the true phase advance of a behavioural oscillator. A second overlap is an invalid tap word that lands in the flag-controlled band. There, the substituted code and the flag must together choose the correction, and the bench judges that case from the stated band rules.

// File: rtl/mpd_pkg.sv
`timescale 1ns/1ps
package mpd_pkg;
    localparam int MPD_TAPS  = 15;
    localparam int MPD_CODES = 2 * MPD_TAPS;
    localparam int MPD_PH_W  = $clog2(MPD_CODES);

    typedef logic [MPD_PH_W-1:0] ph_code_t;

    typedef struct packed {
        ph_code_t code;
        logic     ok;
    } tap_read_t;

    typedef enum logic [1:0] {
        FIX_KEEP   = 2'd0,
        FIX_REGION = 2'd1,
        FIX_FLAG   = 2'd2
    } fix_src_t;

    // Band selection: quarter to three-quarter cycle trusts the flag,
    // past half cycle the region alone decides.
    function automatic fix_src_t pick_fix(input ph_code_t c);
        int v;
        v = int'(c);
        if ((4 * v > MPD_CODES) && (4 * v < 3 * MPD_CODES))
            return FIX_FLAG;
        else if (2 * v > MPD_CODES)
            return FIX_REGION;
        return FIX_KEEP;
    endfunction
endpackage

// File: rtl/mpd_tap_encoder.sv
`timescale 1ns/1ps
module mpd_tap_encoder
    import mpd_pkg::*;
(
    input  logic [MPD_TAPS-1:0] taps,
    output tap_read_t           rd
);
    localparam logic [MPD_TAPS-1:0] ONE = {{(MPD_TAPS-1){1'b0}}, 1'b1};

    logic [MPD_TAPS-1:0] norm;
    int                  ones;

    always_comb begin
        ones  = $countones(taps);
        norm  = taps[MPD_TAPS-1] ? ~taps : taps;
        rd.ok = ((norm & (norm + ONE)) == '0);
        if (taps[MPD_TAPS-1])
            rd.code = ph_code_t'(MPD_CODES - ones);
        else
            rd.code = ph_code_t'(ones);
    end
endmodule

// File: rtl/mpd_cycle_fix.sv
`timescale 1ns/1ps
module mpd_cycle_fix
    import mpd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  ph_code_t         code,
    input  logic             xflag,
    input  logic [CNT_W-1:0] cnt,
    output fix_src_t         src,
    output logic [CNT_W-1:0] cnt_fix
);
    logic dec;

    always_comb begin
        src = pick_fix(code);
        unique case (src)
            FIX_FLAG:   dec = xflag;
            FIX_REGION: dec = 1'b1;
            default:    dec = 1'b0;
        endcase
        cnt_fix = cnt - {{(CNT_W-1){1'b0}}, dec};
    end
endmodule

// File: rtl/mpd_delta_reg.sv
`timescale 1ns/1ps
module mpd_delta_reg
    import mpd_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int OUT_W = CNT_W + MPD_PH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv,
    input  ph_code_t         code,
    input  logic [CNT_W-1:0] cnt_fix,
    input  logic             ok,
    output logic [OUT_W-1:0] word,
    output logic             valid,
    output logic             err
);
    logic [CNT_W-1:0] prev_cnt;
    ph_code_t         prev_code;
    logic             primed;
    logic [CNT_W-1:0] dcnt;
    logic [OUT_W-1:0] delta;

    always_comb begin
        dcnt  = cnt_fix - prev_cnt;
        delta = OUT_W'(dcnt) * OUT_W'(MPD_CODES) + OUT_W'(code) - OUT_W'(prev_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt  <= '0;
            prev_code <= '0;
            primed    <= 1'b0;
            word      <= '0;
            valid     <= 1'b0;
            err       <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (conv) begin
                prev_cnt  <= cnt_fix;
                prev_code <= code;
                primed    <= 1'b1;
                err       <= ~ok;
                if (primed) begin
                    valid <= 1'b1;
                    word  <= delta;
                end
            end
        end
    end

    // First conversion only stores the reference.
    assert_prime_silent_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(primed) |-> !valid);
endmodule

// File: rtl/mpd_phase_digitizer.sv
`timescale 1ns/1ps
module mpd_phase_digitizer
    import mpd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      conv_i,
    input  logic [MPD_TAPS-1:0]       taps_i,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic                      xflag_i,
    output logic [CNT_W+MPD_PH_W-1:0] word_o,
    output logic                      valid_o,
    output logic                      err_o
);
    localparam int OUT_W = CNT_W + MPD_PH_W;

    tap_read_t        rd;
    ph_code_t         held_code;
    ph_code_t         use_code;
    fix_src_t         src;
    logic [CNT_W-1:0] cnt_fix;

    mpd_tap_encoder u_enc (
        .taps (taps_i),
        .rd   (rd)
    );

    always_ff @(posedge clk) begin
        if (rst)
            held_code <= '0;
        else if (conv_i && rd.ok)
            held_code <= rd.code;
    end

    assign use_code = rd.ok ? rd.code : held_code;

    mpd_cycle_fix #(.CNT_W(CNT_W)) u_fix (
        .code    (use_code),
        .xflag   (xflag_i),
        .cnt     (cnt_i),
        .src     (src),
        .cnt_fix (cnt_fix)
    );

    mpd_delta_reg #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_delta (
        .clk     (clk),
        .rst     (rst),
        .conv    (conv_i),
        .code    (use_code),
        .cnt_fix (cnt_fix),
        .ok      (rd.ok),
        .word    (word_o),
        .valid   (valid_o),
        .err     (err_o)
    );

    assert_code_range_R1: assert property (@(posedge clk) disable iff (rst)
        rd.ok |-> (int'(rd.code) < MPD_CODES));

    assert_held_on_bad_R2: assert property (@(posedge clk) disable iff (rst)
        (conv_i && !rd.ok) |=> $stable(held_code));

    assert_upper_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (conv_i && rd.ok && (4 * int'(rd.code) > 3 * MPD_CODES))
            |-> (cnt_fix == cnt_i - {{(CNT_W-1){1'b0}}, 1'b1}));

    assert_lower_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_i && rd.ok && (4 * int'(rd.code) < MPD_CODES)) |-> (cnt_fix == cnt_i));

    assert_valid_follows_conv_R9: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(conv_i));

    assert_err_follows_conv_R2: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(conv_i));
endmodule

// File: tb/mpd_phase_digitizer_tb.sv
`timescale 1ns/1ps
module mpd_phase_digitizer_tb;
    localparam int CW    = 6;
    localparam int OW    = CW + 5;
    localparam int CMASK = (1 << CW) - 1;
    localparam int OMASK = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_i = 1'b0;
    logic [14:0]   taps_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic          xflag_i = 1'b0;
    logic [OW-1:0] word_o;
    logic          valid_o;
    logic          err_o;

    mpd_phase_digitizer #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .conv_i(conv_i), .taps_i(taps_i),
        .cnt_i(cnt_i), .xflag_i(xflag_i),
        .word_o(word_o), .valid_o(valid_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    tt = 0;          // true oscillator phase, 1/30 cycle units
    int    base = 60;       // counter offset, close to full scale
    int    held = 0;
    int    pcf = 0;
    int    pcode = 0;
    bit    primed_b = 0;
    bit    exp_valid = 0;
    bit    exp_err = 0;
    int    exp_word = 0;
    int    last_word = 0;
    string tag = "R6";
    bit    done = 0;

    function automatic logic [14:0] taps_of(input int f);
        logic [14:0] t;
        for (int k = 0; k < 15; k++)
            t[k] = (f < 15) ? (k < f) : (k >= f - 15);
        return t;
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int expv);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic cmp();
        @(negedge clk);
        check(valid_o === exp_valid, primed_b ? "R9 valid" : "R8 valid", int'(valid_o), int'(exp_valid));
        check(err_o === exp_err, "R2 err", int'(err_o), int'(exp_err));
        if (exp_valid) begin
            check(int'(word_o) === exp_word, tag, int'(word_o), exp_word);
            last_word = int'(word_o);
        end else begin
            check(int'(word_o) === last_word, "R9 hold", int'(word_o), last_word);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            cmp();
            conv_i = 1'b0;
            exp_valid = 0;
            exp_err = 0;
        end
    endtask

    // kind 0: true taps; otherwise the given corrupt word
    task automatic conv_step(input int adv, input int kind, input logic [14:0] bad);
        int frac, ct, extra, flag, cap, cf, code, dec;
        cmp();
        tt   += adv;
        frac = tt % 30;
        ct   = tt / 30;
        if (frac >= 8 && frac <= 22) begin
            extra = int'($urandom % 2);
            flag  = extra;
        end else begin
            extra = (frac > 15) ? 1 : 0;
            flag  = int'($urandom % 2);   // must be ignored (R3, R4)
        end
        cap = (ct + extra + base) & CMASK;
        conv_i  = 1'b1;
        cnt_i   = CW'(cap);
        xflag_i = flag[0];
        if (kind == 0) begin
            taps_i = taps_of(frac);
            cf     = (ct + base) & CMASK;
            code   = frac;
            held   = frac;
        end else begin
            taps_i = bad;
            code   = held;
            if (held >= 8 && held <= 22) dec = flag;
            else dec = (held > 15) ? 1 : 0;
            cf = (cap - dec) & CMASK;
        end
        if (kind != 0)               tag = "R1 R6 R2";
        else if (primed_b && cf < pcf) tag = "R1 R6 R7";
        else if (frac < 8)           tag = "R1 R6 R4";
        else if (frac > 22)          tag = "R1 R6 R3";
        else                         tag = "R1 R6 R5";
        exp_valid = primed_b;
        exp_word  = ((((cf - pcf) & CMASK) * 30) + code - pcode) & OMASK;
        exp_err   = (kind != 0);
        primed_b  = 1;
        pcf   = cf;
        pcode = code;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        conv_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(valid_o === 1'b0, "R10 valid", int'(valid_o), 0);
        check(err_o === 1'b0, "R10 err", int'(err_o), 0);
        check(word_o === '0, "R10 word", int'(word_o), 0);
        rst = 1'b0;
        held = 0; primed_b = 0; exp_valid = 0; exp_err = 0; last_word = 0;
    endtask

    initial begin
        do_reset();
        // slow sweep through every code, every band
        for (int i = 0; i < 120; i++) begin
            conv_step(1, 0, '0);
            idle(int'($urandom % 2));
        end
        // one cycle plus one code per period: many counter wraps
        for (int i = 0; i < 80; i++) conv_step(31, 0, '0);
        // irregular advances, back-to-back and spaced
        for (int i = 0; i < 80; i++) begin
            conv_step(int'($urandom % 200), 0, '0);
            idle(int'($urandom % 3));
        end
        // invalid tap words mixed in
        for (int i = 0; i < 60; i++) begin
            if (i % 5 == 2)      conv_step(59, 1, 15'h5555);
            else if (i % 5 == 4) conv_step(37, 2, 15'h0002);
            else                 conv_step(59, 0, '0);
        end
        idle(2);
        // reset again: first conversion must stay silent
        do_reset();
        for (int i = 0; i < 40; i++) begin
            conv_step(int'($urandom % 120) + 1, 0, '0);
            idle(int'($urandom % 2));
        end
        idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule